// File: doc/BRIEF.md
# Two-Stage Watchdog Timer on APB

This peripheral is a down-counting watchdog behind an APB slave port. Software programs a reload value and enables either or both of an interrupt line and a reset-request line. It keeps the system alive by writing the service register at regular intervals. That write acknowledges the interrupt and reloads the count. If the count runs out once, an interrupt is raised and counting starts again from the reload value. If it runs out a second time before the interrupt has been acknowledged, the reset request is raised and the counter halts.

A key register protects the configuration. Writing the key value opens the block for writes, and writing any other value closes it. A test mode lets software drive both output lines directly from a register. A bank of read-only identification bytes sits at the top of the 4 KiB window. The parameter `ALT_VARIANT` selects a second flavour. In that flavour the control register freezes once the interrupt is enabled, the test-mode registers are absent, and a one-bit test register appears in their place. The count advances only on cycles where `tick_en` is high, which gives the counter its own slower time base without a second clock.

Top module: `apb_wdog`

## Requirements
- R1: The control register (offset 0x008) keeps bit 0 as interrupt enable and bit 1 as reset enable. Other written bits are dropped and read as zero.
- R2: A write to the load register (offset 0x000) sets both the reload value and the count to the written value and starts the counter. The count is readable at offset 0x004 and drops by one on each clock with `tick_en` high. An expiry happens on a tick taken while the count is zero, so a reload value N expires after N+1 ticks. A reload value of 0 expires on every tick.
- R3: Any write to the service register (offset 0x00C) clears the raw interrupt and reloads the count from the reload value, whatever the data. It does not clear the reset status and does not restart a halted counter.
- R4: An expiry with no raw interrupt pending sets the raw interrupt and reloads the count. An expiry with the raw interrupt pending sets the reset status and halts the counter at zero. The reset status is cleared only by `presetn`.
- R5: While test mode is off, `irq_o` equals the raw interrupt AND interrupt enable, and `rst_req_o` equals the reset status AND reset enable.
- R6: Writing 0x1ACCE551 to the key register (offset 0xC00) unlocks the block, and any other value locks it. The key register reads 1 when locked and 0 when unlocked. While locked, writes to every other offset are ignored.
- R7: When bit 0 of the test control register (offset 0xF00) is set, bit 1 of the test output register (offset 0xF04) drives `irq_o` and bit 0 drives `rst_req_o`.
- R8: After `presetn`, the reload value and the count are 0xFFFFFFFF and the counter runs. Control, raw interrupt, reset status, lock and the test registers are all zero.
- R9: Twelve identification bytes read from offsets 0xFD0 to 0xFFC in steps of four. The last four, at 0xFF0 to 0xFFC, are 0x0D, 0xF0, 0x05 and 0xB1, and the byte at 0xFE0 is 0x24 in the default flavour. Writes to them are ignored.
- R10: Every transfer completes in its access phase with `pready` high and `pslverr` low. Unmapped offsets, the service register and the test output register all read as zero.
- R11: With `ALT_VARIANT`=1, control writes are ignored once interrupt enable is set. The test registers read zero and have no effect on the outputs. Offset 0x418 holds a readable one-bit register in bit 0, and in the default flavour that offset reads zero.
- R12: Offset 0x010 returns the raw interrupt in bit 0, and offset 0x014 returns the masked interrupt in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | Byte offset inside the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high, no wait states |
| pslverr | output | 1 | Always low |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| irq_o | output | 1 | Interrupt output |
| rst_req_o | output | 1 | Reset request output |

## Verification
A wrong raw interrupt or reset status shows up on `irq_o` or `rst_req_o` on the same cycle it is stored, but only while the matching enable is set. For that reason the bench enables both outputs before it exercises the counter. A count that is off by one only becomes visible at the next expiry, which is up to N+1 ticks later. The bench therefore keeps reload values short and also reads the count directly with ticks paused. A stuck lock or control bit stays silent until the next write to the register it guards, so every lock scenario ends with a write followed by a readback.

// File: rtl/wdog_pkg.sv
// Shared offsets, key and identification bytes for the watchdog.
package wdog_pkg;
    localparam logic [11:0] OFS_LOAD  = 12'h000;
    localparam logic [11:0] OFS_COUNT = 12'h004;
    localparam logic [11:0] OFS_CTRL  = 12'h008;
    localparam logic [11:0] OFS_SERV  = 12'h00C;
    localparam logic [11:0] OFS_RAW   = 12'h010;
    localparam logic [11:0] OFS_MASK  = 12'h014;
    localparam logic [11:0] OFS_TEST  = 12'h418;
    localparam logic [11:0] OFS_KEY   = 12'hC00;
    localparam logic [11:0] OFS_TCTL  = 12'hF00;
    localparam logic [11:0] OFS_TOUT  = 12'hF04;
    localparam logic [11:0] OFS_ID    = 12'hFD0;
    localparam int unsigned ID_COUNT  = 12;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    // Identification byte idx (0 = lowest offset) for the selected flavour.
    function automatic logic [7:0] id_byte(input logic alt, input logic [3:0] idx);
        case (idx)
            4'd0:    return alt ? 8'h00 : 8'h04;
            4'd4:    return alt ? 8'h05 : 8'h24;
            4'd5:    return alt ? 8'h18 : 8'hB8;
            4'd6:    return alt ? 8'h18 : 8'h1B;
            4'd7:    return alt ? 8'h01 : 8'h00;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/wdog_counter.sv
// Down-counter with two-stage expiry.
// Assumes load_wr and clr_wr are never high together (one bus write per cycle).
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_wr,
    input  logic             clr_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] count_q,
    output logic             running_q,
    output logic             ris_q,
    output logic             rs_q
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic expire;
    assign expire = tick_en && running_q && (count_q == '0) && !load_wr && !clr_wr;

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= ALL_ONES;
        else if (load_wr) load_q <= wdata;
    end

    // Count and run state: writes take priority over ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= ALL_ONES;
            running_q <= 1'b1;
        end else if (load_wr) begin
            count_q   <= wdata;
            running_q <= 1'b1;
        end else if (clr_wr) begin
            count_q   <= load_q;
        end else if (expire) begin
            if (!ris_q) count_q   <= load_q;
            else        running_q <= 1'b0;
        end else if (tick_en && running_q) begin
            count_q   <= count_q - 1'b1;
        end
    end

    // Raw interrupt: set on the first expiry, cleared by service.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_wr) ris_q <= 1'b0;
        else if (expire)      ris_q <= 1'b1;
    end

    // Reset status: sticky until bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                rs_q <= 1'b0;
        else if (expire && ris_q)  rs_q <= 1'b1;
    end
endmodule

// File: rtl/wdog_regs.sv
// Control, key and test registers plus write decode for the counter.
// Assumes wr_en marks an APB access-phase write.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter bit ALT_VARIANT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [1:0]        ctrl_q,
    output logic              lock_q,
    output logic              itcr_q,
    output logic [1:0]        itop_q,
    output logic              test_q,
    output logic              load_wr,
    output logic              clr_wr
);
    logic open_wr;
    assign open_wr = wr_en && !lock_q;
    assign load_wr = open_wr && (addr == ADDR_W'(OFS_LOAD));
    assign clr_wr  = open_wr && (addr == ADDR_W'(OFS_SERV));

    // Key register: any write to it is accepted, locked or not.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  lock_q <= 1'b0;
        else if (wr_en && addr == ADDR_W'(OFS_KEY))  lock_q <= (wdata != UNLOCK_KEY);
    end

    // Control register, optionally frozen once the interrupt is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= 2'b00;
        else if (open_wr && addr == ADDR_W'(OFS_CTRL) && !(ALT_VARIANT && ctrl_q[0]))
            ctrl_q <= wdata[1:0];
    end

    generate
        if (!ALT_VARIANT) begin : g_itest
            // Test control and test output registers.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    itcr_q <= 1'b0;
                    itop_q <= 2'b00;
                end else if (open_wr && addr == ADDR_W'(OFS_TCTL)) begin
                    itcr_q <= wdata[0];
                end else if (open_wr && addr == ADDR_W'(OFS_TOUT)) begin
                    itop_q <= wdata[1:0];
                end
            end
            assign test_q = 1'b0;
        end else begin : g_alt
            // One-bit test register of the alternate flavour.
            always_ff @(posedge clk) begin
                if (!rst_n)                                    test_q <= 1'b0;
                else if (open_wr && addr == ADDR_W'(OFS_TEST)) test_q <= wdata[0];
            end
            assign itcr_q = 1'b0;
            assign itop_q = 2'b00;
        end
    endgenerate
endmodule

// File: rtl/apb_wdog.sv
// Top of the two-stage watchdog: APB decode, read mux and output select.
// Assumes ADDR_W >= 12 and CNT_W <= 32; no wait states, no slave errors.
module apb_wdog
    import wdog_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int CNT_W       = 32,
    parameter bit ALT_VARIANT = 1'b0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              tick_en,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam logic [ADDR_W-1:0] ID_LO = ADDR_W'(OFS_ID);

    logic [CNT_W-1:0]  load_q, count_q;
    logic              running_q, ris_q, rs_q;
    logic [1:0]        ctrl_q, itop_q;
    logic              lock_q, itcr_q, test_q;
    logic              load_wr, clr_wr, wr_en;
    logic [ADDR_W-1:0] id_off;

    assign wr_en   = psel && penable && pwrite;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    wdog_regs #(.ADDR_W(ADDR_W), .ALT_VARIANT(ALT_VARIANT)) u_regs (
        .clk(pclk), .rst_n(presetn), .wr_en(wr_en), .addr(paddr), .wdata(pwdata),
        .ctrl_q(ctrl_q), .lock_q(lock_q), .itcr_q(itcr_q), .itop_q(itop_q),
        .test_q(test_q), .load_wr(load_wr), .clr_wr(clr_wr)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(pclk), .rst_n(presetn), .tick_en(tick_en), .load_wr(load_wr),
        .clr_wr(clr_wr), .wdata(pwdata[CNT_W-1:0]), .load_q(load_q),
        .count_q(count_q), .running_q(running_q), .ris_q(ris_q), .rs_q(rs_q)
    );

    // Output select: test override or masked status.
    assign irq_o     = itcr_q ? itop_q[1] : (ris_q && ctrl_q[0]);
    assign rst_req_o = itcr_q ? itop_q[0] : (rs_q && ctrl_q[1]);

    assign id_off = paddr - ID_LO;

    // Read mux for the access phase.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (paddr)
                ADDR_W'(OFS_LOAD):  prdata = 32'(load_q);
                ADDR_W'(OFS_COUNT): prdata = 32'(count_q);
                ADDR_W'(OFS_CTRL):  prdata = {30'd0, ctrl_q};
                ADDR_W'(OFS_RAW):   prdata = {31'd0, ris_q};
                ADDR_W'(OFS_MASK):  prdata = {31'd0, ris_q && ctrl_q[0]};
                ADDR_W'(OFS_KEY):   prdata = {31'd0, lock_q};
                ADDR_W'(OFS_TCTL):  prdata = {31'd0, itcr_q};
                ADDR_W'(OFS_TEST):  prdata = {31'd0, test_q};
                default: begin
                    if (paddr >= ID_LO && id_off[1:0] == 2'b00 &&
                        id_off[ADDR_W-1:2] < (ADDR_W-2)'(ID_COUNT))
                        prdata = {24'd0, id_byte(ALT_VARIANT, id_off[5:2])};
                end
            endcase
        end
    end
endmodule

// File: rtl/wdog_chk.sv
// Property checker for apb_wdog, attached by bind below.
// Assumes it sees the counter and register state of the bound instance.
module wdog_chk #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              tick_en,
    input logic              irq_o,
    input logic              rst_req_o,
    input logic [CNT_W-1:0]  count_q,
    input logic              running_q,
    input logic              ris_q,
    input logic              rs_q,
    input logic              lock_q,
    input logic [1:0]        ctrl_q,
    input logic              itcr_q
);
    logic cnt_hit;
    assign cnt_hit = psel && penable && pwrite && !lock_q &&
                     (paddr == ADDR_W'(12'h000) || paddr == ADDR_W'(12'h00C));

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && running_q && count_q != '0 && !cnt_hit) |=> (count_q == $past(count_q) - 1'b1)); // R2
    AST_RIS_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ris_q) |-> ($past(count_q) == '0)); // R4
    AST_HALT_ON_RESET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rs_q) |-> !running_q); // R4
    AST_RESET_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rs_q |=> rs_q); // R4
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!itcr_q && !ctrl_q[0]) |-> !irq_o); // R5
    AST_RST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!itcr_q && !ctrl_q[1]) |-> !rst_req_o); // R5
    AST_LOCK_FREEZES_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(ctrl_q)); // R6
endmodule

bind apb_wdog wdog_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .tick_en(tick_en), .irq_o(irq_o), .rst_req_o(rst_req_o),
    .count_q(count_q), .running_q(running_q), .ris_q(ris_q), .rs_q(rs_q),
    .lock_q(lock_q), .ctrl_q(ctrl_q), .itcr_q(itcr_q)
);

// File: tb/test_apb_wdog.sv
// Bench: behavioural reference model compared every cycle, plus directed reads.
module test_apb_wdog;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, psel_a = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic        tick_en = 1'b0;
    logic [31:0] prdata, prdata_a;
    logic        pready, pslverr, pready_a, pslverr_a;
    logic        irq_o, rst_req_o, irq_a, rst_a;
    int          n_chk = 0, n_bad = 0;

    always #2 pclk = ~pclk;

    apb_wdog i_apb_wdog (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .tick_en(tick_en), .irq_o(irq_o), .rst_req_o(rst_req_o));

    apb_wdog #(.ALT_VARIANT(1'b1)) i_apb_wdog_alt (
        .pclk(pclk), .presetn(presetn), .psel(psel_a), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a), .pready(pready_a), .pslverr(pslverr_a),
        .tick_en(tick_en), .irq_o(irq_a), .rst_req_o(rst_a));

    // Reference model state for the default instance.
    longint m_load, m_cnt;
    bit m_run, m_ris, m_rs, m_lock, m_itcr;
    bit [1:0] m_ctrl, m_itop;

    always @(posedge pclk) begin
        if (!presetn) begin
            m_load = 64'hFFFF_FFFF; m_cnt = 64'hFFFF_FFFF; m_run = 1;
            m_ris = 0; m_rs = 0; m_lock = 0; m_itcr = 0; m_ctrl = 0; m_itop = 0;
        end else if (psel && penable && pwrite && !m_lock && paddr == 12'h000) begin
            m_load = pwdata; m_cnt = pwdata; m_run = 1;
        end else if (psel && penable && pwrite && !m_lock && paddr == 12'h00C) begin
            m_cnt = m_load; m_ris = 0;
        end else if (tick_en && m_run) begin
            if (m_cnt != 0)  m_cnt = m_cnt - 1;
            else if (!m_ris) begin m_ris = 1; m_cnt = m_load; end
            else begin m_rs = 1; m_run = 0; end
        end
        if (presetn && psel && penable && pwrite) begin
            if (!m_lock && paddr == 12'h008) m_ctrl = pwdata[1:0];
            if (!m_lock && paddr == 12'hF00) m_itcr = pwdata[0];
            if (!m_lock && paddr == 12'hF04) m_itop = pwdata[1:0];
            if (paddr == 12'hC00) m_lock = (pwdata != 32'h1ACCE551);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Every-cycle comparison of both outputs with the model (R5, R7).
    always @(negedge pclk) begin
        #1;
        if (presetn) begin
            check("R5 irq", {31'd0, irq_o},
                  {31'd0, m_itcr ? m_itop[1] : (m_ris && m_ctrl[0])});
            check("R5 rst", {31'd0, rst_req_o},
                  {31'd0, m_itcr ? m_itop[0] : (m_rs && m_ctrl[1])});
        end
    end

    task automatic wr(input bit alt, input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = !alt; psel_a = alt; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; psel_a = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input bit alt, input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge pclk);
        psel = !alt; psel_a = alt; pwrite = 0; paddr = a; penable = 0;
        @(negedge pclk); penable = 1; #1;
        check(req, alt ? prdata_a : prdata, exp);
        check("R10 pready/pslverr", {30'd0, alt ? pready_a : pready, alt ? pslverr_a : pslverr}, 32'h2);
        @(negedge pclk); psel = 0; psel_a = 0; penable = 0;
    endtask

    task automatic do_reset();
        @(negedge pclk); presetn = 0; tick_en = 0;
        repeat (3) @(negedge pclk);
        presetn = 1;
    endtask

    initial begin
        repeat (200000) @(posedge pclk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R8 reset state
        rd(0, 12'h000, 32'hFFFF_FFFF, "R8 load");
        rd(0, 12'h004, 32'hFFFF_FFFF, "R8 count");
        rd(0, 12'h008, 0, "R8 ctrl");
        rd(0, 12'h010, 0, "R8 raw");
        rd(0, 12'hC00, 0, "R8 lock");
        rd(0, 12'hF00, 0, "R8 tctl");
        // R9 identification bytes
        rd(0, 12'hFF0, 32'h0D, "R9 id");
        rd(0, 12'hFF4, 32'hF0, "R9 id");
        rd(0, 12'hFF8, 32'h05, "R9 id");
        rd(0, 12'hFFC, 32'hB1, "R9 id");
        rd(0, 12'hFE0, 32'h24, "R9 id");
        wr(0, 12'hFF0, 32'h77);
        rd(0, 12'hFF0, 32'h0D, "R9 id write ignored");
        // R10 unmapped and write-only offsets
        rd(0, 12'h100, 0, "R10 unmapped");
        rd(0, 12'h00C, 0, "R10 service reads zero");
        rd(0, 12'h418, 0, "R11 test reg absent in default");
        // R1 control mask
        wr(0, 12'h008, 32'hFFFF_FFFF);
        rd(0, 12'h008, 32'h3, "R1 ctrl");
        // R2 load and count
        wr(0, 12'h000, 32'd5);
        rd(0, 12'h004, 32'd5, "R2 count after load");
        tick_en = 1;
        repeat (3) @(negedge pclk);
        tick_en = 0;
        rd(0, 12'h004, 32'd2, "R2 count decrements");
        // R4 first expiry
        tick_en = 1;
        repeat (3) @(negedge pclk);
        tick_en = 0;
        check("R4 irq after first expiry", {31'd0, irq_o}, 32'd1);
        rd(0, 12'h004, 32'd5, "R4 count reloaded");
        rd(0, 12'h010, 1, "R12 raw");
        rd(0, 12'h014, 1, "R12 masked");
        // R4 second expiry
        tick_en = 1;
        repeat (10) @(negedge pclk);
        check("R4 reset request", {31'd0, rst_req_o}, 32'd1);
        rd(0, 12'h004, 0, "R4 counter halted");
        // R3 service clears raw interrupt but not reset status
        wr(0, 12'h00C, 32'h0);
        rd(0, 12'h010, 0, "R3 raw cleared");
        check("R3 reset status kept", {30'd0, irq_o, rst_req_o}, 32'd1);
        rd(0, 12'h004, 32'd5, "R3 count reloaded");
        repeat (4) @(negedge pclk);
        rd(0, 12'h004, 32'd5, "R3 halted counter stays");
        // R3 periodic service prevents expiry
        do_reset();
        wr(0, 12'h008, 32'h3);
        wr(0, 12'h000, 32'd20);
        tick_en = 1;
        for (int i = 0; i < 6; i++) begin
            repeat (12) @(negedge pclk);
            wr(0, 12'h00C, 32'hDEAD_BEEF);
        end
        check("R3 serviced no irq", {30'd0, irq_o, rst_req_o}, 32'd0);
        // R2 zero reload expires every tick
        tick_en = 0;
        wr(0, 12'h000, 32'd0);
        tick_en = 1; @(negedge pclk); tick_en = 0;
        check("R2 zero load first expiry", {30'd0, irq_o, rst_req_o}, 32'd2);
        tick_en = 1; @(negedge pclk); tick_en = 0;
        check("R2 zero load second expiry", {30'd0, irq_o, rst_req_o}, 32'd3);
        // R6 lock
        do_reset();
        wr(0, 12'h008, 32'h1);
        wr(0, 12'hC00, 32'h0);
        rd(0, 12'hC00, 1, "R6 locked");
        wr(0, 12'h008, 32'h2);
        rd(0, 12'h008, 32'h1, "R6 ctrl frozen");
        wr(0, 12'h000, 32'h55);
        rd(0, 12'h000, 32'hFFFF_FFFF, "R6 load frozen");
        wr(0, 12'hC00, 32'h1ACCE551);
        rd(0, 12'hC00, 0, "R6 unlocked");
        wr(0, 12'h008, 32'h2);
        rd(0, 12'h008, 32'h2, "R6 ctrl writable");
        // R7 test override
        wr(0, 12'hF00, 32'h1);
        wr(0, 12'hF04, 32'h2);
        check("R7 drive irq", {30'd0, irq_o, rst_req_o}, 32'd2);
        wr(0, 12'hF04, 32'h1);
        check("R7 drive rst", {30'd0, irq_o, rst_req_o}, 32'd1);
        rd(0, 12'hF00, 1, "R7 tctl");
        rd(0, 12'hF04, 0, "R10 test output reads zero");
        wr(0, 12'hF00, 32'h0);
        check("R7 override off", {30'd0, irq_o, rst_req_o}, 32'd0);
        // R11 alternate flavour
        wr(1, 12'h008, 32'h1);
        wr(1, 12'h008, 32'h0);
        rd(1, 12'h008, 32'h1, "R11 ctrl frozen");
        wr(1, 12'hF00, 32'h1);
        wr(1, 12'hF04, 32'h3);
        rd(1, 12'hF00, 0, "R11 no test ctl");
        check("R11 outputs not overridden", {30'd0, irq_a, rst_a}, 32'd0);
        wr(1, 12'h418, 32'h1);
        rd(1, 12'h418, 32'h1, "R11 test reg");
        rd(1, 12'hFE0, 32'h05, "R9 alt id");
        rd(1, 12'hFF0, 32'h0D, "R9 alt id");
        repeat (2) @(negedge pclk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule